// File: doc/BRIEF.md
# Parallel-Test DRAM Array Model

A synthesizable behavioural model of a by-four dynamic RAM with a small array, meant to sit behind a memory controller in a testbench or to be driven by built-in self-test logic. The strobes are sampled on a clock: a change of the active-low row strobe, column strobe or write strobe takes effect at the first rising edge that sees the new level. The levels on the column and write strobes at the moment the row strobe falls decide what the row cycle is: a row access with a latched row address, a refresh with the column strobe ahead of the row strobe, or a refresh that also arms the compressed test mode.

In normal mode the model holds 4-bit words at the full row and column address, with writes either at the column strobe fall (write strobe already low) or when the write strobe falls later while the column strobe is held low. Several column cycles may follow one row fall. In test mode the array is seen as 16 bits wide: the two lowest column bits are dropped, a write copies each data pin's bit into all four words of the addressed group, and a read returns, per pin, whether that pin's four cells agree. Test mode is left by a column-before-row refresh with the write strobe high or by a row cycle that ends without any column strobe fall.

Top module: `dram_tm_model`

## Requirements
- R1: After reset the test-mode flag is 0 and the data output enable is 0.
- R2: A row strobe fall with the column strobe high latches the row address; each later column strobe fall latches the column address, and a write strobe low at that fall stores dqIn at {row, column}; with the write strobe high a read returns the stored word.
- R3: If the write strobe falls while the column strobe stays low after a column was latched, dqIn is stored at the latched address.
- R4: Several column cycles within one low period of the row strobe each use their own column address against the same row.
- R5: dqOe is 1 only while a row access is open, a column has been latched, the column strobe and output enable are low and the write strobe is high; otherwise it is 0.
- R6: A row strobe fall with both the column strobe and the write strobe low sets the test-mode flag and leaves the array contents unchanged.
- R7: A row strobe fall with the column strobe low and the write strobe high clears the test-mode flag, changes no stored data and does not enable the output.
- R8: A row cycle in which the row strobe rises again without any column strobe fall clears the test-mode flag and changes no stored data.
- R9: In test mode a write ignores column bits 1:0 and stores dqIn into all four words {row, column[hi:2], 0..3}.
- R10: In test mode a read drives on pin p a 1 when bit p of the four words {row, column[hi:2], 0..3} is equal in all four, else 0.
- R11: A row strobe fall with column and write strobes low while already in test mode keeps test mode set.
- R12: The test-mode flag changes only at a clock edge on which a row strobe transition is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write strobe, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dqIn | input | DQ_W | Write data from the bus |
| dqOut | output | DQ_W | Read data or per-pin agreement flags |
| dqOe | output | 1 | High when dqOut is to be driven onto the bus |
| testMode | output | 1 | Compressed test mode is active |

## Verification
The write strobe falling while a read is being driven is the case where two functions meet on one edge: the delayed write stores the new word and the output enable drops at that same edge. The bench opens a read with the output enabled, pulls the write strobe low while the column strobe stays low, and checks that the enable is gone after that edge; it then raises the write strobe again and checks that the output returns the newly written word rather than the old one. The column latch and the early write also coincide on the column strobe fall, which the fast-page sequence judges by reading back every column of the row.

// File: rtl/dram_tm_pkg.sv
package dram_tm_pkg;

  // Number of low column bits folded together in test mode
  localparam int GROUP_SEL_W = 2;
  localparam int GROUP_SIZE  = 1 << GROUP_SEL_W;

  // Strobes from the control to the datapath, valid for one clock
  typedef struct packed {
    logic rowLoad;   // latch the row address
    logic colLoad;   // latch the column address
    logic wrEn;      // store dqIn this edge
    logic readEn;    // drive the output
    logic testMode;  // compressed mode is active
  } ctrlStrobes_t;

endpackage

// File: rtl/dram_tm_ctrl.sv
module dram_tm_ctrl
  import dram_tm_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         rasN,
  input  logic         casN,
  input  logic         weN,
  input  logic         oeN,
  output ctrlStrobes_t ctl
);

  logic rasPrev, casPrev, wePrev;
  logic rowOpen, casSeen, colValid, testModeQ;
  logic rasFall, rasRise, casFall, weFall;
  logic rowLoad, colLoad, delayedWr, wrEn, readEn;
  logic setTest, clrTest;

  always_comb begin
    rasFall   = rasPrev & ~rasN;
    rasRise   = ~rasPrev & rasN;
    casFall   = casPrev & ~casN;
    weFall    = wePrev & ~weN;
    // Row cycle kind is fixed by the strobe levels at the row fall
    rowLoad   = rasFall & casN;
    setTest   = rasFall & ~casN & ~weN;
    clrTest   = (rasFall & ~casN & weN) | (rasRise & rowOpen & ~casSeen);
    colLoad   = rowOpen & ~rasN & casFall;
    delayedWr = rowOpen & colValid & ~rasN & ~casN & ~casFall & weFall;
    wrEn      = (colLoad & ~weN) | delayedWr;
    readEn    = rowOpen & colValid & ~rasN & ~casN & ~oeN & weN;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rasPrev   <= 1'b1;
      casPrev   <= 1'b1;
      wePrev    <= 1'b1;
      rowOpen   <= 1'b0;
      casSeen   <= 1'b0;
      colValid  <= 1'b0;
      testModeQ <= 1'b0;
    end else begin
      rasPrev <= rasN;
      casPrev <= casN;
      wePrev  <= weN;
      if (rowLoad)      rowOpen <= 1'b1;
      else if (rasRise) rowOpen <= 1'b0;
      if (rowLoad)      casSeen <= 1'b0;
      else if (colLoad) casSeen <= 1'b1;
      if (rowLoad || rasRise) colValid <= 1'b0;
      else if (colLoad)       colValid <= 1'b1;
      if (setTest)      testModeQ <= 1'b1;
      else if (clrTest) testModeQ <= 1'b0;
    end
  end

  always_comb begin
    ctl.rowLoad  = rowLoad;
    ctl.colLoad  = colLoad;
    ctl.wrEn     = wrEn;
    ctl.readEn   = readEn;
    ctl.testMode = testModeQ;
  end

  // R6: write strobe and column strobe low at the row fall arm test mode
  assert_tmset_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(rasN) && !casN && !weN) |=> testModeQ);

  // R7: column-first refresh with write strobe high leaves test mode
  assert_cbrexit_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(rasN) && !casN && weN) |=> !testModeQ);

  // R12: no row strobe transition, no mode change
  assert_modehold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!$fell(rasN) && !$rose(rasN)) |=> $stable(testModeQ));

endmodule

// File: rtl/dram_tm_datapath.sv
module dram_tm_datapath
  import dram_tm_pkg::*;
#(
  parameter int ROW_W = 4,
  parameter int COL_W = 4,
  parameter int DQ_W  = 4,
  parameter int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      ctl,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dqIn,
  output logic [DQ_W-1:0]   dqOut
);

  localparam int IDX_W = ROW_W + COL_W;
  localparam int DEPTH = 1 << IDX_W;
  localparam int GRP_W = IDX_W - GROUP_SEL_W;

  logic [DQ_W-1:0]  mem [DEPTH];
  logic [ROW_W-1:0] rowReg;
  logic [COL_W-1:0] colReg;
  logic [COL_W-1:0] wrCol;
  logic [IDX_W-1:0] wrIdx;
  logic [GRP_W-1:0] wrGrp;
  logic [GRP_W-1:0] rdGrp;
  logic [DQ_W-1:0]  grpWord [GROUP_SIZE];
  logic [DQ_W-1:0]  agree;
  logic [DQ_W-1:0]  plainWord;

  // Address latches
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowReg <= '0;
      colReg <= '0;
    end else begin
      if (ctl.rowLoad) rowReg <= addr[ROW_W-1:0];
      if (ctl.colLoad) colReg <= addr[COL_W-1:0];
    end
  end

  // An early write uses the column presented on this same edge
  always_comb begin
    wrCol = ctl.colLoad ? addr[COL_W-1:0] : colReg;
    wrIdx = {rowReg, wrCol};
    wrGrp = {rowReg, wrCol[COL_W-1:GROUP_SEL_W]};
    rdGrp = {rowReg, colReg[COL_W-1:GROUP_SEL_W]};
  end

  always_ff @(posedge clk) begin
    if (ctl.wrEn) begin
      if (ctl.testMode) begin
        for (int k = 0; k < GROUP_SIZE; k++)
          mem[{wrGrp, GROUP_SEL_W'(k)}] <= dqIn;
      end else begin
        mem[wrIdx] <= dqIn;
      end
    end
  end

  // Words of the addressed group, for the compressed read
  always_comb begin
    for (int k = 0; k < GROUP_SIZE; k++)
      grpWord[k] = mem[{rdGrp, GROUP_SEL_W'(k)}];
  end

  // Per-pin agreement of the four cells behind each pin
  for (genvar p = 0; p < DQ_W; p++) begin : g_pinCmp
    logic allOne, allZero;
    always_comb begin
      allOne  = 1'b1;
      allZero = 1'b1;
      for (int k = 0; k < GROUP_SIZE; k++) begin
        allOne  = allOne & grpWord[k][p];
        allZero = allZero & ~grpWord[k][p];
      end
    end
    assign agree[p] = allOne | allZero;
  end

  assign plainWord = mem[{rowReg, colReg}];
  assign dqOut     = ctl.testMode ? agree : plainWord;

  // R9: a test-mode write leaves the first and last word of the group equal to the data
  assert_grpfill_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wrEn && ctl.testMode) |=>
      ((mem[{$past(wrGrp), 2'b00}] == $past(dqIn)) &&
       (mem[{$past(wrGrp), 2'b11}] == $past(dqIn))));

endmodule

// File: rtl/dram_tm_model.sv
module dram_tm_model
  import dram_tm_pkg::*;
#(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 4,
  parameter int DQ_W   = 4,
  parameter int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dqIn,
  output logic [DQ_W-1:0]   dqOut,
  output logic              dqOe,
  output logic              testMode
);

  ctrlStrobes_t ctl;

  dram_tm_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .rasN (rasN),
    .casN (casN),
    .weN  (weN),
    .oeN  (oeN),
    .ctl  (ctl)
  );

  dram_tm_datapath #(
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .DQ_W   (DQ_W),
    .ADDR_W (ADDR_W)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .ctl   (ctl),
    .addr  (addr),
    .dqIn  (dqIn),
    .dqOut (dqOut)
  );

  assign dqOe     = ctl.readEn;
  assign testMode = ctl.testMode;

endmodule

// File: tb/tb_dram_tm_model.sv
`timescale 1ns/1ps
module tb_dram_tm_model;

  localparam int ROW_W = 4;
  localparam int COL_W = 4;
  localparam int DQ_W  = 4;
  localparam int ADDR_W = 4;

  localparam logic [3:0] OP_WR = 4'd1, OP_RD = 4'd2, OP_TWR = 4'd3,
                         OP_TRD = 4'd4, OP_SET = 4'd5, OP_CBR = 4'd6, OP_RON = 4'd7;

  // {op, row, col, data, expected}
  localparam int NV = 25;
  localparam logic [19:0] VEC [NV] = '{
    20'h110A0, 20'h11150, 20'h112F0, 20'h11300,   // row 1 group: A,5,F,0
    20'h21105, 20'h2100A,                         // R2 reads
    20'h12430, 20'h12530, 20'h12630, 20'h12770,   // row 2 group: 3,3,3,7
    20'h22707,
    20'h50001,                                    // R6 enter test mode
    20'h41200, 20'h4250B,                         // R10 compressed reads
    20'h33960, 20'h4380F,                         // R9 group write, read all agree
    20'h50001,                                    // R11 stay in test mode
    20'h60000,                                    // R7 exit
    20'h23A06, 20'h23B06,                         // R9 column bits ignored
    20'h50001, 20'h75000,                         // R8 row-only refresh exit
    20'h22603,                                    // data intact
    20'h60000, 20'h21105                          // R7 normal-mode refresh, data intact
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rasN = 1'b1, casN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DQ_W-1:0]   dqIn = '0;
  logic [DQ_W-1:0]   dqOut;
  logic              dqOe, testMode;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dram_tm_model #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .weN(weN), .oeN(oeN),
    .addr(addr), .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe), .testMode(testMode)
  );

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic openRow(input logic [3:0] r);
    addr = r; rasN = 1'b0; tick();
  endtask

  task automatic closeRow;
    casN = 1'b1; oeN = 1'b1; weN = 1'b1; tick();
    rasN = 1'b1; tick();
  endtask

  task automatic writeCol(input logic [3:0] c, input logic [3:0] d);
    addr = c; dqIn = d; weN = 1'b0; casN = 1'b0; tick();
    chk(!dqOe, "R5 write", {7'd0, dqOe}, 8'h00);
    casN = 1'b1; weN = 1'b1; tick();
  endtask

  task automatic readCol(input logic [3:0] c, output logic [3:0] got, output logic oe);
    addr = c; weN = 1'b1; oeN = 1'b0; casN = 1'b0; tick();
    got = dqOut; oe = dqOe;
    casN = 1'b1; oeN = 1'b1; tick();
  endtask

  task automatic cbr(input logic we);
    casN = 1'b0; weN = we; tick();
    rasN = 1'b0; tick();
    chk(!dqOe, "R7 refresh output", {7'd0, dqOe}, 8'h00);
    rasN = 1'b1; tick();
    casN = 1'b1; weN = 1'b1; tick();
  endtask

  task automatic rasOnly(input logic [3:0] r);
    addr = r; rasN = 1'b0; tick();
    rasN = 1'b1; tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] got;
    logic oe;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    chk(testMode == 1'b0 && dqOe == 1'b0, "R1 reset", {6'd0, testMode, dqOe}, 8'h00);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      logic [3:0] op, r, c, d, e;
      {op, r, c, d, e} = VEC[i];
      case (op)
        OP_WR, OP_TWR: begin openRow(r); writeCol(c, d); closeRow(); end
        OP_RD: begin
          openRow(r); readCol(c, got, oe); closeRow();
          chk(oe && got == e, "R2/R9 read", {3'd0, oe, got}, {4'h1, e});
        end
        OP_TRD: begin
          openRow(r); readCol(c, got, oe); closeRow();
          chk(oe && got == e, "R9/R10 compressed read", {3'd0, oe, got}, {4'h1, e});
        end
        OP_SET: begin
          cbr(1'b0);
          chk(testMode == e[0], "R6/R11 test set", {7'd0, testMode}, {7'd0, e[0]});
        end
        OP_CBR: begin
          cbr(1'b1);
          chk(testMode == e[0], "R7 refresh exit", {7'd0, testMode}, {7'd0, e[0]});
        end
        OP_RON: begin
          rasOnly(r);
          chk(testMode == e[0], "R8 row-only exit", {7'd0, testMode}, {7'd0, e[0]});
        end
        default: ;
      endcase
    end

    // R4: fast page, four columns under one row fall
    openRow(4'd6);
    for (int c = 0; c < 4; c++) writeCol(4'(c), 4'(c + 8));
    for (int c = 0; c < 4; c++) begin
      readCol(4'(c), got, oe);
      chk(oe && got == 4'(c + 8), "R4 page read", {3'd0, oe, got}, {4'h1, 4'(c + 8)});
    end
    closeRow();

    // R5: output enable gating
    openRow(4'd6);
    addr = 4'd1; weN = 1'b1; oeN = 1'b1; casN = 1'b0; tick();
    chk(!dqOe, "R5 oe high", {7'd0, dqOe}, 8'h00);
    oeN = 1'b0; tick();
    chk(dqOe && dqOut == 4'h9, "R5 oe low", {3'd0, dqOe, dqOut}, 8'h19);
    casN = 1'b1; tick();
    chk(!dqOe, "R5 cas high", {7'd0, dqOe}, 8'h00);
    closeRow();

    // R3 + R5 same edge: delayed write during an enabled read
    openRow(4'd6);
    addr = 4'd2; weN = 1'b1; oeN = 1'b0; casN = 1'b0; dqIn = 4'hC; tick();
    chk(dqOe && dqOut == 4'hA, "R3 before delayed write", {3'd0, dqOe, dqOut}, 8'h1A);
    weN = 1'b0; tick();
    chk(!dqOe, "R3/R5 enable drops on write", {7'd0, dqOe}, 8'h00);
    weN = 1'b1; tick();
    chk(dqOe && dqOut == 4'hC, "R3 new word visible", {3'd0, dqOe, dqOut}, 8'h1C);
    closeRow();
    openRow(4'd6); readCol(4'd2, got, oe); closeRow();
    chk(oe && got == 4'hC, "R3 readback", {3'd0, oe, got}, 8'h1C);

    // R12: strobe activity without a row strobe edge leaves the mode alone
    cbr(1'b0);
    casN = 1'b0; weN = 1'b0; tick();
    casN = 1'b1; weN = 1'b1; tick();
    chk(testMode == 1'b1, "R12 mode held", {7'd0, testMode}, 8'h01);
    rasOnly(4'd0);
    chk(testMode == 1'b0, "R8 exit again", {7'd0, testMode}, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule